// File: doc/BRIEF.md
# Clock-Stop SPI Master Engine

This block is the transmit/receive core of an SPI master whose serial clock exists only while a word is moving. A host places a word of 8 to 32 bits on `tx_word`, selects its length on `len_cfg` and a clock divider on `div_cfg`, and pulses `start`. The engine pulls the active-low select line, drives the first bit and, after a lead-in, runs the serial clock. It shifts the word out most-significant bit first and gathers the bits returned on `miso`. It then releases the data line, raises select and pulses `done` with the received word.

The serial clock rests high. A transfer opens with a falling edge. Outgoing bits change after falling edges and incoming bits are captured on rising edges. The divider sets both the period and the split between the high and low phases. An even divider gives the high phase one cycle more than the low phase. An odd divider splits the period evenly.

Top module: `spi_cs_master`

## Requirements
- R1: After synchronous reset, `sclk` is 1, `ss_n` is 1, `mosi_oe` is 0, and `busy`, `done` and `rx_word` are 0. While idle, `sclk` stays 1, `ss_n` stays 1 and `mosi_oe` stays 0.
- R2: With an effective divider D, each serial clock period lasts D+1 `clk` cycles. For even D the high phase is D/2+1 cycles and the low phase is D/2 cycles.
- R3: For odd D both phases last (D+1)/2 cycles. A programmed divider of 0 acts as D = 1.
- R4: `ss_n` falls with `mosi_oe` rising and the first bit on `mosi` exactly one high-phase width before the first falling edge of `sclk`. `sclk` toggles only while `ss_n` is low.
- R5: The word is sent most-significant bit first: bit len-1 of `tx_word` down to bit 0. `mosi` changes only after falling `sclk` edges and holds through each high phase.
- R6: `miso` is captured on each rising `sclk` edge. `rx_word` holds the len captured bits right-aligned, with the first captured bit at position len-1 and the upper bits zero.
- R7: `mosi_oe` drops one high-phase width after the last rising `sclk` edge. `ss_n` returns high one full period (D+1 cycles) after that edge.
- R8: `done` is a one-cycle pulse in the cycle `ss_n` returns high, and `rx_word` is valid in that same cycle.
- R9: A `start` pulse while `busy` is 1 is ignored. The running transfer keeps its latched word, length and divider, and no further transfer follows.
- R10: A `len_cfg` below 8 transfers 8 bits. A `len_cfg` above 32 transfers 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transfer (honoured only while idle) |
| div_cfg | input | DIV_W | Serial clock divider D |
| len_cfg | input | LEN_W | Word length in bits |
| tx_word | input | MAXW | Word to send, right-aligned |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Gated serial clock, idles high |
| ss_n | output | 1 | Slave select, active low |
| mosi | output | 1 | Serial data to the slave |
| mosi_oe | output | 1 | Output enable for `mosi` (0 = high impedance) |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_word | output | MAXW | Received word, right-aligned |

## Verification
The assertions assume that `start` arrives only as a level sampled at `clk` edges. They also assume that configuration inputs matter only in the cycle a transfer is accepted: the divider, length and word are latched at that moment, so later changes must not disturb the transfer. The stimulus keeps `miso` stable from its change after a falling `sclk` edge through the next rising edge. A bench slave model drives it only on falling edges, and never on the first one, which only opens the transfer. The stimulus also changes configuration inputs and pulses `start` during a transfer, to confirm that both are ignored while busy.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_LEAD,
      SEQ_LOW,
      SEQ_HIGH,
      SEQ_TAIL
   } seq_state_t;
endpackage

// File: rtl/spi_cs_phase.sv
// Converts the divider into high and low phase widths (in clk cycles).
module spi_cs_phase #(
   parameter int DIV_W = 8
) (
   input  logic [DIV_W-1:0] div_in,
   output logic [DIV_W-1:0] hi_w,
   output logic [DIV_W-1:0] lo_w
);
   generate
      if (DIV_W < 2) begin : g_bad_div_w
         $error("spi_cs_phase: DIV_W must be at least 2");
      end
   endgenerate

   logic [DIV_W-1:0] d_eff;

   always_comb begin
      // zero is not a usable divider; treat it as one
      d_eff = (div_in == '0) ? DIV_W'(1) : div_in;
      // even d: d/2+1 high, d/2 low; odd d: (d+1)/2 each
      hi_w  = (d_eff >> 1) + DIV_W'(1);
      lo_w  = (d_eff >> 1) + DIV_W'(d_eff[0]);
   end
endmodule

// File: rtl/spi_cs_shift.sv
// Transmit and receive shift registers, MSB first.
module spi_cs_shift #(
   parameter int MAXW  = 32,
   parameter int LEN_W = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic [MAXW-1:0] tx_in,
   input  logic [LEN_W-1:0] len_in,
   input  logic            adv,
   input  logic            cap,
   input  logic            sin,
   output logic            sout,
   output logic [MAXW-1:0] rx_out
);
   generate
      if (MAXW < 2 || (1 << LEN_W) <= MAXW) begin : g_bad_shift_cfg
         $error("spi_cs_shift: LEN_W too narrow for MAXW");
      end
   endgenerate

   logic [MAXW-1:0] tx_sh;
   logic [MAXW-1:0] rx_sh;

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_sh <= '0;
         rx_sh <= '0;
      end else if (load) begin
         // left-align so the word's top bit sits at the output end
         tx_sh <= tx_in << (LEN_W'(MAXW) - len_in);
         rx_sh <= '0;
      end else begin
         if (adv) tx_sh <= {tx_sh[MAXW-2:0], 1'b0};
         if (cap) rx_sh <= {rx_sh[MAXW-2:0], sin};
      end
   end

   assign sout   = tx_sh[MAXW-1];
   assign rx_out = rx_sh;
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
   import spi_cs_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int MAXW  = 32,
   parameter int MINW  = 8,
   parameter int LEN_W = $clog2(MAXW + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [DIV_W-1:0] div_cfg,
   input  logic [LEN_W-1:0] len_cfg,
   input  logic [MAXW-1:0]  tx_word,
   input  logic             miso,
   output logic             sclk,
   output logic             ss_n,
   output logic             mosi,
   output logic             mosi_oe,
   output logic             busy,
   output logic             done,
   output logic [MAXW-1:0]  rx_word
);
   generate
      if (MINW < 1 || MINW > MAXW) begin : g_bad_len_range
         $error("spi_cs_master: MINW must lie in 1..MAXW");
      end
   endgenerate

   seq_state_t       st;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] hi_w, lo_w;
   logic [DIV_W-1:0] cnt;
   logic [LEN_W-1:0] bits_left;
   logic [LEN_W-1:0] len_eff;
   logic             sclk_q, ss_q, oe_q, done_q;
   logic [MAXW-1:0]  rx_q, rx_sh;
   logic             load, adv, cap, sout;
   logic             hi_end, lo_end;

   spi_cs_phase #(.DIV_W(DIV_W)) u_phase (
      .div_in (div_q),
      .hi_w   (hi_w),
      .lo_w   (lo_w)
   );

   always_comb begin
      if (len_cfg < LEN_W'(MINW))      len_eff = LEN_W'(MINW);
      else if (len_cfg > LEN_W'(MAXW)) len_eff = LEN_W'(MAXW);
      else                             len_eff = len_cfg;
      hi_end = (cnt == hi_w - DIV_W'(1));
      lo_end = (cnt == lo_w - DIV_W'(1));
      load   = (st == SEQ_IDLE) && start;
      cap    = (st == SEQ_LOW) && lo_end;
      adv    = (st == SEQ_HIGH) && hi_end && (bits_left != '0);
   end

   spi_cs_shift #(.MAXW(MAXW), .LEN_W(LEN_W)) u_shift (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .tx_in  (tx_word),
      .len_in (len_eff),
      .adv    (adv),
      .cap    (cap),
      .sin    (miso),
      .sout   (sout),
      .rx_out (rx_sh)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= SEQ_IDLE;
         div_q     <= '0;
         cnt       <= '0;
         bits_left <= '0;
         sclk_q    <= 1'b1;
         ss_q      <= 1'b1;
         oe_q      <= 1'b0;
         done_q    <= 1'b0;
         rx_q      <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            SEQ_IDLE: if (start) begin
               div_q     <= div_cfg;
               bits_left <= len_eff;
               cnt       <= '0;
               ss_q      <= 1'b0;
               oe_q      <= 1'b1;
               st        <= SEQ_LEAD;
            end
            SEQ_LEAD: if (hi_end) begin
               cnt    <= '0;
               sclk_q <= 1'b0;
               st     <= SEQ_LOW;
            end else cnt <= cnt + DIV_W'(1);
            SEQ_LOW: if (lo_end) begin
               cnt       <= '0;
               sclk_q    <= 1'b1;
               bits_left <= bits_left - LEN_W'(1);
               st        <= SEQ_HIGH;
            end else cnt <= cnt + DIV_W'(1);
            SEQ_HIGH: if (hi_end) begin
               cnt <= '0;
               if (bits_left == '0) begin
                  oe_q <= 1'b0;
                  st   <= SEQ_TAIL;
               end else begin
                  sclk_q <= 1'b0;
                  st     <= SEQ_LOW;
               end
            end else cnt <= cnt + DIV_W'(1);
            SEQ_TAIL: if (lo_end) begin
               cnt    <= '0;
               ss_q   <= 1'b1;
               done_q <= 1'b1;
               rx_q   <= rx_sh;
               st     <= SEQ_IDLE;
            end else cnt <= cnt + DIV_W'(1);
            default: st <= SEQ_IDLE;
         endcase
      end
   end

   assign sclk    = sclk_q;
   assign ss_n    = ss_q;
   assign mosi_oe = oe_q;
   assign mosi    = oe_q & sout;
   assign busy    = (st != SEQ_IDLE);
   assign done    = done_q;
   assign rx_word = rx_q;

   // R1: idle lines rest in their inactive levels
   assert_idle_lines_R1: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (sclk && ss_n && !mosi_oe));

   // R3: phases never differ by more than one cycle and high is never shorter
   assert_phase_split_R3: assert property (@(posedge clk) disable iff (rst)
      busy |-> ((hi_w >= lo_w) && (hi_w - lo_w <= DIV_W'(1)) && (lo_w != '0)));

   // R4: the serial clock moves only under an active select
   assert_clk_gated_R4: assert property (@(posedge clk) disable iff (rst)
      !$stable(sclk) |-> !ss_n);

   // R5: data holds while the clock stays high during a transfer
   assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (sclk && $past(sclk) && mosi_oe && $past(mosi_oe)) |-> $stable(mosi));

   // R7: output is released with the clock high and select still low
   assert_oe_release_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(mosi_oe) |-> (sclk && !ss_n));

   // R8: done lasts one cycle and coincides with select rising
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   assert_done_with_ss_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> $rose(ss_n));

   // R9: the latched divider is untouched during a transfer
   assert_cfg_held_R9: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(div_q));
endmodule

// File: tb/sim_spi_cs_master.sv
module sim_spi_cs_master;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [7:0]  div_cfg = '0;
   logic [5:0]  len_cfg = 6'd8;
   logic [31:0] tx_word = '0;
   logic        miso = 1'b0;
   logic        sclk, ss_n, mosi, mosi_oe, busy, done;
   logic [31:0] rx_word;

   int checks = 0;
   int errors = 0;

   typedef struct {
      int          dv;
      int          ln;
      logic [31:0] tx;
      logic [31:0] rx;
   } exp_t;
   exp_t q[$];

   int          cur_len = 8;
   logic [31:0] cur_sl  = '0;
   int          sidx    = 0;
   bit          first_fall = 1'b0;

   always #2 clk = ~clk;

   spi_cs_master u0 (
      .clk(clk), .rst(rst), .start(start), .div_cfg(div_cfg),
      .len_cfg(len_cfg), .tx_word(tx_word), .miso(miso), .sclk(sclk),
      .ss_n(ss_n), .mosi(mosi), .mosi_oe(mosi_oe), .busy(busy),
      .done(done), .rx_word(rx_word)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int hi_of(input int d);
      return d / 2 + 1;
   endfunction
   function automatic int lo_of(input int d);
      return (d % 2 == 1) ? (d + 1) / 2 : d / 2;
   endfunction

   // Slave model: first bit on select fall, next bits after later falling edges
   always @(negedge ss_n) begin
      sidx = cur_len - 1;
      first_fall = 1'b1;
      miso = cur_sl[sidx];
   end
   always @(negedge sclk) begin
      if (ss_n === 1'b0) begin
         if (first_fall) first_fall = 1'b0;
         else if (sidx > 0) begin
            sidx = sidx - 1;
            miso = cur_sl[sidx];
         end
      end
   end

   // Monitor: pops expectations and measures every phase at the ports
   initial begin : monitor
      exp_t e;
      int hw, lw, n, m;
      forever begin
         @(negedge clk);
         if (rst === 1'b0 && ss_n === 1'b0) begin
            if (q.size() == 0) begin
               chk(1'b0, "R9 unexpected transfer", 32'd1, 32'd0);
               while (ss_n === 1'b0) @(negedge clk);
            end else begin
               e  = q.pop_front();
               hw = hi_of(e.dv);
               lw = lo_of(e.dv);
               chk(mosi_oe === 1'b1 && mosi === e.tx[e.ln-1], "R4 first bit at select",
                   {30'd0, mosi_oe, mosi}, {31'd1, e.tx[e.ln-1]});
               n = 0;
               while (sclk === 1'b1 && ss_n === 1'b0) begin n++; @(negedge clk); end
               chk(n == hw, "R4 lead width", n, hw);
               for (int b = 0; b < e.ln; b++) begin
                  n = 0;
                  while (sclk === 1'b0) begin n++; @(negedge clk); end
                  chk(n == lw, "R2/R3 low width", n, lw);
                  chk(mosi === e.tx[e.ln-1-b], "R5 bit order", mosi, e.tx[e.ln-1-b]);
                  n = 0;
                  if (b < e.ln - 1) begin
                     while (sclk === 1'b1) begin n++; @(negedge clk); end
                     chk(n == hw, "R2/R3 high width", n, hw);
                  end else begin
                     while (mosi_oe === 1'b1) begin n++; @(negedge clk); end
                     chk(n == hw, "R7 release delay", n, hw);
                     m = n;
                     while (ss_n === 1'b0) begin m++; @(negedge clk); end
                     chk(m == hw + lw, "R7 select tail", m, hw + lw);
                     chk(done === 1'b1, "R8 done with select", done, 1);
                     chk(rx_word === e.rx, "R6 received word", rx_word, e.rx);
                     @(negedge clk);
                     chk(done === 1'b0, "R8 done single cycle", done, 0);
                  end
               end
            end
         end
      end
   end

   task automatic xfer(input int dv, input int ln, input logic [31:0] tx,
                       input logic [31:0] sl, input bit poke);
      exp_t e;
      logic [63:0] mask;
      e.dv = (dv == 0) ? 1 : dv;
      e.ln = (ln < 8) ? 8 : ((ln > 32) ? 32 : ln);
      mask = (64'd1 << e.ln) - 64'd1;
      e.tx = tx;
      e.rx = sl & mask[31:0];
      while (busy !== 1'b0) @(negedge clk);
      cur_len = e.ln;
      cur_sl  = sl;
      q.push_back(e);
      div_cfg = dv[7:0];
      len_cfg = ln[5:0];
      tx_word = tx;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      if (poke) begin
         repeat (3) @(negedge clk);
         tx_word = ~tx;
         div_cfg = 8'd7;
         len_cfg = 6'd9;
         start   = 1'b1;
         @(negedge clk);
         start   = 1'b0;
      end
      while (done !== 1'b1) @(negedge clk);
      repeat (3) @(negedge clk);
      if (poke) begin
         for (int i = 0; i < 12; i++) begin
            chk(busy === 1'b0 && ss_n === 1'b1, "R9 no extra transfer",
                {30'd0, busy, ss_n}, 32'd1);
            @(negedge clk);
         end
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(sclk === 1'b1, "R1 sclk idle", sclk, 1);
      chk(ss_n === 1'b1, "R1 select idle", ss_n, 1);
      chk(mosi_oe === 1'b0, "R1 output disabled", mosi_oe, 0);
      chk(busy === 1'b0 && done === 1'b0, "R1 flags", {busy, done}, 0);
      chk(rx_word === 32'd0, "R1 rx cleared", rx_word, 0);

      xfer(1, 8, 32'h0000_00A5, 32'h0000_003C, 1'b0);   // R3 odd minimum
      xfer(2, 8, 32'h0000_005A, 32'h0000_00C3, 1'b0);   // R2 even
      xfer(0, 16, 32'h0000_8001, 32'h0000_7FFE, 1'b0);  // R3 zero divider
      xfer(4, 12, 32'h0000_0ABC, 32'hFFFF_F123, 1'b0);  // R2 even, R6 upper bits zero
      xfer(5, 32, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);  // R3 odd, full width
      xfer(3, 4, 32'h0000_0096, 32'h0000_0169, 1'b0);   // R10 short length
      xfer(2, 40, 32'hC001_D00D, 32'h8765_4321, 1'b0);  // R10 long length
      xfer(6, 10, 32'h0000_02D3, 32'h0000_0155, 1'b1);  // R9 start while busy

      repeat (5) @(negedge clk);
      chk(q.size() == 0, "R9 all expectations consumed", q.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule